// File: doc/BRIEF.md
# Unsigned Array Multiplier

This block multiplies two unsigned operands of equal width in a single combinational pass and returns the full double-width product. There is no clock, no register and no handshake: the product follows the operands after the settling time of the array, so a surrounding pipeline can register the inputs and outputs wherever its timing budget needs them.

The array is built from identical cells. Each cell holds one AND gate and one full adder. A row of cells adds the multiplicand, gated by one multiplier bit, to the partial product that the previous row passes down. The first row starts from a partial product of all zeros. Each row sits one bit position further toward the most significant end. That placement, and no shifter or multiplexer, provides the shift-and-add weighting. The carry out of the last cell in a row becomes the top bit of that row's outgoing partial product. The lowest bit of each row is a finished product bit. The last row supplies the upper half of the product.

Top module: `amul_top`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned product of `mcand` and `mplier`, expressed in 2*WIDTH bits.
- R2: When `mplier` is zero, `product` is zero for every `mcand`.
- R3: When `mcand` is zero, `product` is zero for every `mplier`.
- R4: When `mplier` is one, `product` equals `mcand` zero-extended to 2*WIDTH bits.
- R5: When both operands are all ones, `product` equals (2^WIDTH-1)^2. For WIDTH=4 that value is 225 (binary 11100001).
- R6: With WIDTH=4, operands 13 (1101) and 11 (1011) give a product of 143 (10001111).
- R7: When `mplier` is 2^k, `product` equals `mcand` shifted left by k places.
- R8: Swapping the two operands leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier; bit i gates row i |
| product | output | 2*WIDTH | Unsigned double-width product |

## Verification
The bench builds two copies of the array: one with WIDTH=4 and one with WIDTH=6. It sweeps every operand pair on both. With four bits, the 256 pairs include the 13 by 11 case and the all-ones corner at 225. The six-bit copy has 4096 pairs. It checks that the generate indexing and the carry handling at the top of each row stay correct when rows and columns are longer than in the nominal build. Directed tasks on both widths cover zero operands, a multiplier of one, the powers of two, and swapped operands.

// File: rtl/amul_pkg.sv
package amul_pkg;

  typedef struct packed {
    logic carryOut;
    logic sumBit;
  } addResult_t;

  function automatic addResult_t fullAdd(input logic a, input logic b, input logic c);
    addResult_t r;
    r.sumBit   = a ^ b ^ c;
    r.carryOut = (a & b) | (a & c) | (b & c);
    return r;
  endfunction

endpackage

// File: rtl/amul_cell.sv
module amul_cell
  import amul_pkg::*;
(
  input  logic ppIn,
  input  logic mBit,
  input  logic qBit,
  input  logic cIn,
  output logic ppOut,
  output logic cOut
);
  logic       gated;
  addResult_t res;

  always_comb begin
    gated = mBit & qBit;
    res   = fullAdd(ppIn, gated, cIn);
    ppOut = res.sumBit;
    cOut  = res.carryOut;
  end

  // cell arithmetic: two output bits equal the count of ones among the addends
  always_comb begin
    if (!$isunknown({ppIn, mBit, qBit, cIn}))
      p_cell_sum_r1: assert ({cOut, ppOut} == 2'(ppIn) + 2'(mBit && qBit) + 2'(cIn))
        else $error("cell sum mismatch");
  end
endmodule

// File: rtl/amul_row.sv
module amul_row #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] ppIn,
  input  logic [WIDTH-1:0] mcand,
  input  logic             qBit,
  output logic [WIDTH:0]   ppOut
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sumBits;

  assign carry[0] = 1'b0;

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    amul_cell u_cell (
      .ppIn (ppIn[j]),
      .mBit (mcand[j]),
      .qBit (qBit),
      .cIn  (carry[j]),
      .ppOut(sumBits[j]),
      .cOut (carry[j+1])
    );
  end

  // final carry of the row becomes the top bit of the outgoing partial product
  assign ppOut = {carry[WIDTH], sumBits};

  always_comb begin
    if (!$isunknown({ppIn, mcand, qBit}))
      p_row_accumulate_r1: assert (ppOut == ({1'b0, ppIn} + (qBit ? {1'b0, mcand} : '0)))
        else $error("row accumulate mismatch");
  end
endmodule

// File: rtl/amul_array.sv
module amul_array #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int ROWS = WIDTH;

  logic [WIDTH:0]   rowOut [ROWS];
  logic [WIDTH-1:0] rowIn  [ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    if (i == 0) begin : g_first
      assign rowIn[i] = '0;
    end else begin : g_next
      assign rowIn[i] = rowOut[i-1][WIDTH:1];
    end

    amul_row #(.WIDTH(WIDTH)) u_row (
      .ppIn (rowIn[i]),
      .mcand(mcand),
      .qBit (mplier[i]),
      .ppOut(rowOut[i])
    );

    assign product[i] = rowOut[i][0];
  end

  assign product[2*WIDTH-1:WIDTH] = rowOut[ROWS-1][WIDTH:1];
endmodule

// File: rtl/amul_top.sv
module amul_top #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  amul_array #(.WIDTH(WIDTH)) u_array (
    .mcand  (mcand),
    .mplier (mplier),
    .product(product)
  );

  always_comb begin
    if (!$isunknown({mcand, mplier})) begin
      p_full_product_r1: assert (product == PW'(PW'(mcand) * PW'(mplier)))
        else $error("product mismatch");
      p_zero_mplier_r2: assert (mplier != '0 || product == '0)
        else $error("zero multiplier gives nonzero product");
      p_zero_mcand_r3: assert (mcand != '0 || product == '0)
        else $error("zero multiplicand gives nonzero product");
      p_unit_mplier_r4: assert (mplier != WIDTH'(1) || product == PW'(mcand))
        else $error("unit multiplier mismatch");
      p_one_hot_shift_r7: assert (!$onehot(mplier) || product == (PW'(mcand) << $clog2(mplier)))
        else $error("power-of-two multiplier mismatch");
    end
  end
endmodule

// File: tb/amul_top_test.sv
module amul_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0] a4, b4;
  logic [7:0] p4;
  logic [5:0] a6, b6;
  logic [11:0] p6;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  amul_top #(.WIDTH(4)) uut     (.mcand(a4), .mplier(b4), .product(p4));
  amul_top #(.WIDTH(6)) uutWide (.mcand(a6), .mplier(b6), .product(p6));

  task automatic apply(input int x, input int y, input int xw, input int yw);
    @(posedge clk);
    #1;
    a4 = 4'(x); b4 = 4'(y); a6 = 6'(xw); b6 = 6'(yw);
    @(negedge clk);
  endtask

  task automatic check4(input string req, input int expv);
    checks++;
    if (p4 !== 8'(expv)) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d product=%0d expected=%0d", req, a4, b4, p4, expv);
    end
  endtask

  task automatic check6(input string req, input int expv);
    checks++;
    if (p6 !== 12'(expv)) begin
      errors++;
      $display("FAIL %s (wide): a=%0d b=%0d product=%0d expected=%0d", req, a6, b6, p6, expv);
    end
  endtask

  task automatic test_reset_state;
    apply(0, 0, 0, 0);
    check4("R3 reset state", 0);
    check6("R3 reset state", 0);
  endtask

  task automatic test_exhaustive_r1;
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++) begin
        apply(x % 16, y % 16, x, y);
        if (x < 16 && y < 16) check4("R1", x * y);
        check6("R1", x * y);
      end
  endtask

  task automatic test_zero_r2_r3;
    for (int x = 0; x < 64; x++) begin
      apply(x % 16, 0, x, 0);
      check4("R2", 0); check6("R2", 0);
      apply(0, x % 16, 0, x);
      check4("R3", 0); check6("R3", 0);
    end
  endtask

  task automatic test_unit_r4;
    for (int x = 0; x < 64; x++) begin
      apply(x % 16, 1, x, 1);
      check4("R4", x % 16); check6("R4", x);
    end
  endtask

  task automatic test_all_ones_r5;
    apply(15, 15, 63, 63);
    check4("R5", 225);
    check6("R5", 3969);
  endtask

  task automatic test_example_r6;
    apply(13, 11, 13, 11);
    check4("R6", 143);
    check6("R6", 143);
  endtask

  task automatic test_shift_r7;
    for (int k = 0; k < 6; k++)
      for (int x = 0; x < 64; x += 7) begin
        apply(x % 16, (k < 4) ? (1 << k) : 0, x, 1 << k);
        if (k < 4) check4("R7", (x % 16) << k);
        check6("R7", x << k);
      end
  endtask

  task automatic test_swap_r8;
    int first4, first6;
    for (int x = 0; x < 64; x += 5)
      for (int y = 0; y < 64; y += 3) begin
        apply(x % 16, y % 16, x, y);
        first4 = int'(p4); first6 = int'(p6);
        apply(y % 16, x % 16, y, x);
        check4("R8", first4);
        check6("R8", first6);
      end
  endtask

  initial begin
    a4 = '0; b4 = '0; a6 = '0; b6 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_reset_state();
    test_example_r6();
    test_all_ones_r5();
    test_zero_r2_r3();
    test_unit_r4();
    test_shift_r7();
    test_swap_r8();
    test_exhaustive_r1();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule